// File: doc/BRIEF.md
# In-Place Radix-2 FFT Sequencer

This block runs a complete in-place, decimation-in-time FFT over an external memory of N complex 16-bit samples, where N is a power of two. A one-cycle `start` pulse begins the job. The block first reorders the memory into bit-reversed order, swapping each index pair only once. It then runs log2(N) butterfly stages. Each butterfly reads two complex words, fetches its twiddle factor from an external sine table, and writes both results back in place. The inputs of every butterfly are halved, so the finished spectrum is the true DFT divided by N.

The sample memory and the table both have a registered read port with a latency of one cycle. The sample memory also has one write port. The twiddle cosine is taken from the same sine table at an offset of N/4, so the table must hold at least 3N/4 entries of round(32767·sin(2πn/N)). When the last word has been written, `done` pulses for one cycle and the block returns to idle.

Top module: `fft_inplace_seq`

## Requirements
- R1: During reset and until the first accepted start, `busy`, `done`, `mem_we` and `tbl_re` are all low.
- R2: A `start` seen while idle raises `busy` in the next cycle. `done` is high for exactly one cycle, the cycle right after the final memory write. `busy` is low in the cycle after `done`.
- R3: A `start` that arrives while busy is ignored. The run takes the same number of cycles, produces one `done`, and gives the same memory contents. While idle there is no memory write and no table read.
- R4: The reorder pass visits indices 1 to N-2. An index m is exchanged with r = bit-reverse(m) over log2(N) bits only when r > m. Each exchange is exactly two writes, and all reorder writes come before the first table read.
- R5: For butterfly position m in a stage with shift k, the cosine is read at table address (m<<k)+N/4 and then the sine at m<<k. The first two table reads of a run are therefore N/4 and then 0. No table address reaches 3N/4.
- R6: The twiddle is w = (c>>>1) + j·((-s)>>>1). The product t = w·x[i+L] uses (a·b)>>>15 truncated to 16 bits for each partial product. With q = x[i]>>>1, the block writes x[i+L] = q−t and then x[i] = q+t, all in 16-bit wrap-around arithmetic. The final memory matches this recipe bit for bit.
- R7: The span L starts at 1 and doubles after each stage up to N/2, and k starts at log2(N)-1. Every stage writes each location once, so a run makes N·log2(N) butterfly writes.
- R8: The output is scaled by 1/N. A constant input c gives bin 0 within log2(N)+2 of c and every other bin within that same bound of zero. An impulse of height A at index 0 gives A/N in every bin within that bound.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a transform (taken only when idle) |
| busy | output | 1 | High from the cycle after start through the done cycle |
| done | output | 1 | One-cycle completion pulse |
| mem_re | output | 1 | Sample memory read enable |
| mem_raddr | output | LOG2N | Sample memory read address |
| mem_rdata_re | input | DW | Real read data, one cycle after the address |
| mem_rdata_im | input | DW | Imaginary read data, one cycle after the address |
| mem_we | output | 1 | Sample memory write enable |
| mem_waddr | output | LOG2N | Sample memory write address |
| mem_wdata_re | output | DW | Real write data |
| mem_wdata_im | output | DW | Imaginary write data |
| tbl_re | output | 1 | Sine table read enable |
| tbl_addr | output | LOG2N | Sine table address |
| tbl_data | input | DW | Sine table data, one cycle after the address |

## Verification
The assertions assume two things about the environment. First, `start` is a single-cycle request. Second, the memory and table return data exactly one cycle after the address with no stall, because the sequencer has no wait input and samples read data at a fixed step. The bench models both memories as registered arrays with that latency. It loads data only while the block is idle, and it drives `start` for one cycle, except for the deliberate second pulse in the middle of a run that tests R3. The table contents are generated by the bench over the full N entries, so every address the block can issue falls inside the table.

// File: rtl/fftseq_pkg.sv
package fftseq_pkg;

  typedef enum logic [3:0] {
    S_IDLE, S_BR_EVAL, S_BR_RDA, S_BR_RDB, S_BR_WA, S_BR_WB,
    S_TW_RC, S_TW_RS, S_TW_CAP,
    S_BF_RDI, S_BF_RDJ, S_BF_WJ, S_BF_WI, S_DONE
  } seq_state_e;

  // reverse a 16-bit index, then drop to the 'keep' low bits
  function automatic logic [15:0] rev_index(input logic [15:0] v, input int unsigned keep);
    logic [15:0] r;
    for (int b = 0; b < 16; b++) r[15-b] = v[b];
    return r >> (16 - keep);
  endfunction

endpackage

// File: rtl/fftseq_twiddle.sv
module fftseq_twiddle #(
  parameter int LOG2N = 10,
  parameter int DW    = 16,
  parameter int KW    = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [LOG2N-1:0]     pos,
  input  logic [KW-1:0]        kshift,
  input  logic                 cap_cos,
  input  logic                 cap_sin,
  input  logic signed [DW-1:0] tbl_data,
  output logic [LOG2N-1:0]     cos_idx,
  output logic [LOG2N-1:0]     sin_idx,
  output logic signed [DW-1:0] w_re,
  output logic signed [DW-1:0] w_im
);
  localparam int N = 1 << LOG2N;
  localparam logic [LOG2N-1:0] QTR = LOG2N'(N / 4);

  logic [LOG2N-1:0]     tj;
  logic signed [DW:0]   neg_s;

  assign tj      = pos << kshift;
  assign sin_idx = tj;
  assign cos_idx = tj + QTR;
  assign neg_s   = -$signed({tbl_data[DW-1], tbl_data});

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      w_re <= '0;
      w_im <= '0;
    end else begin
      if (cap_cos) w_re <= tbl_data >>> 1;
      if (cap_sin) w_im <= DW'(neg_s >>> 1);
    end
  end
endmodule

// File: rtl/fftseq_bfly.sv
module fftseq_bfly #(
  parameter int DW = 16
) (
  input  logic signed [DW-1:0] top_re,
  input  logic signed [DW-1:0] top_im,
  input  logic signed [DW-1:0] bot_re,
  input  logic signed [DW-1:0] bot_im,
  input  logic signed [DW-1:0] w_re,
  input  logic signed [DW-1:0] w_im,
  output logic signed [DW-1:0] sum_re,
  output logic signed [DW-1:0] sum_im,
  output logic signed [DW-1:0] dif_re,
  output logic signed [DW-1:0] dif_im
);
  function automatic logic signed [DW-1:0] mulq(input logic signed [DW-1:0] a,
                                                input logic signed [DW-1:0] b);
    logic signed [2*DW-1:0] p;
    p = (2*DW)'(a) * (2*DW)'(b);
    return DW'(p >>> (DW - 1));
  endfunction

  logic signed [DW-1:0] t_re, t_im, q_re, q_im;

  assign t_re   = mulq(w_re, bot_re) - mulq(w_im, bot_im);
  assign t_im   = mulq(w_re, bot_im) + mulq(w_im, bot_re);
  assign q_re   = top_re >>> 1;
  assign q_im   = top_im >>> 1;
  assign sum_re = q_re + t_re;
  assign sum_im = q_im + t_im;
  assign dif_re = q_re - t_re;
  assign dif_im = q_im - t_im;
endmodule

// File: rtl/fft_inplace_seq.sv
module fft_inplace_seq
  import fftseq_pkg::*;
#(
  parameter int LOG2N = 10,
  parameter int DW    = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  output logic                 busy,
  output logic                 done,
  output logic                 mem_re,
  output logic [LOG2N-1:0]     mem_raddr,
  input  logic signed [DW-1:0] mem_rdata_re,
  input  logic signed [DW-1:0] mem_rdata_im,
  output logic                 mem_we,
  output logic [LOG2N-1:0]     mem_waddr,
  output logic signed [DW-1:0] mem_wdata_re,
  output logic signed [DW-1:0] mem_wdata_im,
  output logic                 tbl_re,
  output logic [LOG2N-1:0]     tbl_addr,
  input  logic signed [DW-1:0] tbl_data
);
  localparam int AW = LOG2N;
  localparam int N  = 1 << LOG2N;
  localparam int KW = $clog2(LOG2N + 1);
  localparam logic [AW-1:0] LAST_BR = AW'(N - 2);
  localparam logic [AW-1:0] HALF    = AW'(N / 2);
  localparam logic [KW-1:0] K_INIT  = KW'(LOG2N - 1);

  seq_state_e state_q;
  logic [AW-1:0] m_br_q, pos_q, idx_q, span_q;
  logic [KW-1:0] k_q;
  logic signed [DW-1:0] hold_re_q, hold_im_q, sum_re_q, sum_im_q;

  // reorder index and its partner
  logic [15:0] br_m16, br_mr16;
  logic        br_swap;
  assign br_m16  = 16'(m_br_q);
  assign br_mr16 = rev_index(br_m16, LOG2N);
  assign br_swap = br_mr16 > br_m16;

  // butterfly addressing
  logic [AW-1:0] hi_addr;
  logic [AW:0]   idx_nx;
  assign hi_addr = idx_q + span_q;
  assign idx_nx  = {1'b0, idx_q} + {span_q, 1'b0};

  // twiddle fetch
  logic cap_cos, cap_sin;
  logic [AW-1:0] cos_idx, sin_idx;
  logic signed [DW-1:0] w_re, w_im;

  fftseq_twiddle #(.LOG2N(LOG2N), .DW(DW), .KW(KW)) u_tw (
    .clk(clk), .rst_n(rst_n), .pos(pos_q), .kshift(k_q),
    .cap_cos(cap_cos), .cap_sin(cap_sin), .tbl_data(tbl_data),
    .cos_idx(cos_idx), .sin_idx(sin_idx), .w_re(w_re), .w_im(w_im)
  );

  logic signed [DW-1:0] bf_sum_re, bf_sum_im, bf_dif_re, bf_dif_im;

  fftseq_bfly #(.DW(DW)) u_bf (
    .top_re(hold_re_q), .top_im(hold_im_q),
    .bot_re(mem_rdata_re), .bot_im(mem_rdata_im),
    .w_re(w_re), .w_im(w_im),
    .sum_re(bf_sum_re), .sum_im(bf_sum_im),
    .dif_re(bf_dif_re), .dif_im(bf_dif_im)
  );

  // named events for the checker
  logic ev_br_wr2, ev_bf_hi;
  assign ev_br_wr2 = (state_q == S_BR_WB);
  assign ev_bf_hi  = (state_q == S_BF_WJ);

  assign busy = (state_q != S_IDLE);
  assign done = (state_q == S_DONE);

  always_comb begin
    mem_re       = 1'b0;
    mem_raddr    = m_br_q;
    mem_we       = 1'b0;
    mem_waddr    = m_br_q;
    mem_wdata_re = mem_rdata_re;
    mem_wdata_im = mem_rdata_im;
    tbl_re       = 1'b0;
    tbl_addr     = cos_idx;
    cap_cos      = 1'b0;
    cap_sin      = 1'b0;
    unique case (state_q)
      S_BR_RDA: mem_re = 1'b1;
      S_BR_RDB: begin mem_re = 1'b1; mem_raddr = br_mr16[AW-1:0]; end
      S_BR_WA:  mem_we = 1'b1;
      S_BR_WB: begin
        mem_we       = 1'b1;
        mem_waddr    = br_mr16[AW-1:0];
        mem_wdata_re = hold_re_q;
        mem_wdata_im = hold_im_q;
      end
      S_TW_RC:  tbl_re = 1'b1;
      S_TW_RS:  begin tbl_re = 1'b1; tbl_addr = sin_idx; cap_cos = 1'b1; end
      S_TW_CAP: cap_sin = 1'b1;
      S_BF_RDI: begin mem_re = 1'b1; mem_raddr = idx_q; end
      S_BF_RDJ: begin mem_re = 1'b1; mem_raddr = hi_addr; end
      S_BF_WJ: begin
        mem_we       = 1'b1;
        mem_waddr    = hi_addr;
        mem_wdata_re = bf_dif_re;
        mem_wdata_im = bf_dif_im;
      end
      S_BF_WI: begin
        mem_we       = 1'b1;
        mem_waddr    = idx_q;
        mem_wdata_re = sum_re_q;
        mem_wdata_im = sum_im_q;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q   <= S_IDLE;
      m_br_q    <= '0;
      pos_q     <= '0;
      idx_q     <= '0;
      span_q    <= AW'(1);
      k_q       <= K_INIT;
      hold_re_q <= '0;
      hold_im_q <= '0;
      sum_re_q  <= '0;
      sum_im_q  <= '0;
    end else begin
      unique case (state_q)
        S_IDLE: if (start) begin
          m_br_q  <= AW'(1);
          state_q <= S_BR_EVAL;
        end
        S_BR_EVAL: begin
          if (br_swap)                state_q <= S_BR_RDA;
          else if (m_br_q == LAST_BR) begin
            span_q <= AW'(1); k_q <= K_INIT; pos_q <= '0; state_q <= S_TW_RC;
          end else begin
            m_br_q <= m_br_q + 1'b1;
          end
        end
        S_BR_RDA: state_q <= S_BR_RDB;
        S_BR_RDB: begin
          hold_re_q <= mem_rdata_re;
          hold_im_q <= mem_rdata_im;
          state_q   <= S_BR_WA;
        end
        S_BR_WA: state_q <= S_BR_WB;
        S_BR_WB: begin
          if (m_br_q == LAST_BR) begin
            span_q <= AW'(1); k_q <= K_INIT; pos_q <= '0; state_q <= S_TW_RC;
          end else begin
            m_br_q  <= m_br_q + 1'b1;
            state_q <= S_BR_EVAL;
          end
        end
        S_TW_RC:  state_q <= S_TW_RS;
        S_TW_RS:  state_q <= S_TW_CAP;
        S_TW_CAP: begin idx_q <= pos_q; state_q <= S_BF_RDI; end
        S_BF_RDI: state_q <= S_BF_RDJ;
        S_BF_RDJ: begin
          hold_re_q <= mem_rdata_re;
          hold_im_q <= mem_rdata_im;
          state_q   <= S_BF_WJ;
        end
        S_BF_WJ: begin
          sum_re_q <= bf_sum_re;
          sum_im_q <= bf_sum_im;
          state_q  <= S_BF_WI;
        end
        S_BF_WI: begin
          if (!idx_nx[AW]) begin
            idx_q   <= idx_nx[AW-1:0];
            state_q <= S_BF_RDI;
          end else if (pos_q != span_q - 1'b1) begin
            pos_q   <= pos_q + 1'b1;
            state_q <= S_TW_RC;
          end else if (span_q == HALF) begin
            state_q <= S_DONE;
          end else begin
            span_q  <= span_q << 1;
            k_q     <= k_q - 1'b1;
            pos_q   <= '0;
            state_q <= S_TW_RC;
          end
        end
        S_DONE:  state_q <= S_IDLE;
        default: state_q <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/fftseq_chk.sv
module fftseq_chk #(
  parameter int LOG2N = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             busy,
  input logic             done,
  input logic             mem_we,
  input logic [LOG2N-1:0] mem_waddr,
  input logic             tbl_re,
  input logic [LOG2N-1:0] tbl_addr,
  input logic [LOG2N-1:0] span,
  input logic             br_wr,
  input logic [15:0]      br_m,
  input logic [15:0]      br_mr,
  input logic             bf_hi
);
  localparam int N = 1 << LOG2N;
  localparam logic [LOG2N:0] TLIM = (LOG2N+1)'(3 * N / 4);

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R2
  AST_DONE_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(mem_we)); // R2
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mem_we && !tbl_re)); // R3
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done && start) |=> busy); // R3
  AST_SWAP_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    br_wr |-> (br_mr > br_m)); // R4
  AST_TBL_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    tbl_re |-> ({1'b0, tbl_addr} < TLIM)); // R5
  AST_PAIR_SPAN: assert property (@(posedge clk) disable iff (!rst_n)
    bf_hi |=> (mem_we && (mem_waddr + span == $past(mem_waddr)))); // R6
  AST_SPAN_POW2: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(span) == 1); // R7
endmodule

bind fft_inplace_seq fftseq_chk #(.LOG2N(LOG2N)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .mem_we(mem_we), .mem_waddr(mem_waddr), .tbl_re(tbl_re), .tbl_addr(tbl_addr),
  .span(span_q), .br_wr(ev_br_wr2), .br_m(br_m16), .br_mr(br_mr16), .bf_hi(ev_bf_hi)
);

// File: tb/test_fft_inplace_seq.sv
`timescale 1ns/1ps
module test_fft_inplace_seq;
  localparam int LOG2N = 5;
  localparam int N     = 1 << LOG2N;
  localparam int TOL   = LOG2N + 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic busy, done, mem_re, mem_we, tbl_re;
  logic [LOG2N-1:0] mem_raddr, mem_waddr, tbl_addr;
  logic signed [15:0] rd_re, rd_im, wd_re, wd_im, tq;

  always #2 clk = ~clk;

  fft_inplace_seq #(.LOG2N(LOG2N), .DW(16)) i_fft_inplace_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
    .mem_re(mem_re), .mem_raddr(mem_raddr), .mem_rdata_re(rd_re), .mem_rdata_im(rd_im),
    .mem_we(mem_we), .mem_waddr(mem_waddr), .mem_wdata_re(wd_re), .mem_wdata_im(wd_im),
    .tbl_re(tbl_re), .tbl_addr(tbl_addr), .tbl_data(tq)
  );

  logic signed [15:0] m_re [N];
  logic signed [15:0] m_im [N];
  logic signed [15:0] sin_tab [N];
  logic signed [15:0] in_re [N];
  logic signed [15:0] in_im [N];
  logic signed [15:0] ex_re [N];
  logic signed [15:0] ex_im [N];
  logic ld_en = 1'b0;
  logic [LOG2N-1:0] ld_addr = '0;
  logic signed [15:0] ld_re = '0, ld_im = '0;

  always @(posedge clk) begin
    if (ld_en) begin
      m_re[ld_addr] <= ld_re;
      m_im[ld_addr] <= ld_im;
    end else if (mem_we) begin
      m_re[mem_waddr] <= wd_re;
      m_im[mem_waddr] <= wd_im;
    end
    rd_re <= m_re[mem_raddr];
    rd_im <= m_im[mem_raddr];
    tq    <= sin_tab[tbl_addr];
  end

  int checks = 0;
  int errors = 0;
  int ref_cycles = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int rev_idx(input int p);
    int r = 0;
    for (int b = 0; b < LOG2N; b++) r = (r << 1) | ((p >> b) & 1);
    return r;
  endfunction

  function automatic logic signed [15:0] qmul(input logic signed [15:0] a,
                                             input logic signed [15:0] b);
    int pr = int'(a) * int'(b);
    return 16'(pr >>> 15);
  endfunction

  task automatic compute_ref();
    for (int p = 0; p < N; p++) begin
      ex_re[p] = in_re[rev_idx(p)];
      ex_im[p] = in_im[rev_idx(p)];
    end
    for (int s = 0; s < LOG2N; s++) begin
      int half = 1 << s;
      int stride = N / (2 * half);
      for (int b = 0; b < N; b += 2 * half) begin
        for (int m = 0; m < half; m++) begin
          int tw = m * stride;
          int top = b + m;
          int bot = top + half;
          int ns = -int'(sin_tab[tw]);
          logic signed [15:0] cr, ci, tr, ti, qr, qi;
          cr = sin_tab[tw + N/4] >>> 1;
          ci = 16'(ns >>> 1);
          tr = qmul(cr, ex_re[bot]) - qmul(ci, ex_im[bot]);
          ti = qmul(cr, ex_im[bot]) + qmul(ci, ex_re[bot]);
          qr = ex_re[top] >>> 1;
          qi = ex_im[top] >>> 1;
          ex_re[bot] = qr - tr;  ex_im[bot] = qi - ti;
          ex_re[top] = qr + tr;  ex_im[top] = qi + ti;
        end
      end
    end
  endtask

  task automatic load_mem();
    for (int p = 0; p < N; p++) begin
      @(negedge clk);
      ld_en = 1'b1; ld_addr = LOG2N'(p); ld_re = in_re[p]; ld_im = in_im[p];
    end
    @(negedge clk);
    ld_en = 1'b0;
  endtask

  // runs one transform; checks protocol, write counts, table order, result
  task automatic run_fft(input string name, input bit poke, output int cyc);
    int brw = 0, bfw = 0, tcount = 0, t0 = -1, t1 = -1, tmax = 0, dones = 0;
    int exp_brw = 0, bad = -1;
    bit prev_we = 0, fin = 0, after_we = 0, quiet = 1;
    compute_ref();
    for (int p = 1; p <= N - 2; p++) if (rev_idx(p) > p) exp_brw += 2;
    load_mem();
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cyc = 0;
    check(busy === 1'b1, "R2", {name, " busy after start"}, int'(busy), 1);
    while (!fin && cyc < 20000) begin
      if (mem_we) begin
        if (tcount == 0) brw++; else bfw++;
      end
      if (tbl_re) begin
        if (tcount == 0) t0 = int'(tbl_addr);
        if (tcount == 1) t1 = int'(tbl_addr);
        if (int'(tbl_addr) > tmax) tmax = int'(tbl_addr);
        tcount++;
      end
      if (done) begin
        dones++; after_we = prev_we; fin = 1;
      end
      prev_we = mem_we;
      start = (poke && cyc == 60);
      @(negedge clk);
      cyc++;
    end
    start = 1'b0;
    check(fin, "R2", {name, " done seen"}, int'(fin), 1);
    check(after_we, "R2", {name, " done follows last write"}, int'(after_we), 1);
    check(busy === 1'b0 && done === 1'b0, "R2", {name, " idle after done"}, int'(busy), 0);
    for (int w = 0; w < 5; w++) begin
      if (mem_we || tbl_re || done) quiet = 0;
      if (done) dones++;
      @(negedge clk);
    end
    check(quiet, "R3", {name, " no activity while idle"}, int'(quiet), 1);
    check(dones == 1, "R3", {name, " single done"}, dones, 1);
    check(brw == exp_brw, "R4", {name, " reorder writes"}, brw, exp_brw);
    check(t0 == N/4 && t1 == 0, "R5", {name, " first table reads"}, t0 * 1000 + t1, (N/4) * 1000);
    check(tmax < 3*N/4, "R5", {name, " table address bound"}, tmax, 3*N/4 - 1);
    check(bfw == N * LOG2N, "R7", {name, " butterfly writes"}, bfw, N * LOG2N);
    for (int p = 0; p < N; p++)
      if (bad < 0 && (m_re[p] !== ex_re[p] || m_im[p] !== ex_im[p])) bad = p;
    if (bad < 0) check(1'b1, "R6", {name, " bit-exact result"}, 0, 0);
    else check(1'b0, "R6", $sformatf("%s bin %0d re", name, bad),
               int'(m_re[bad]), int'(ex_re[bad]));
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check(busy === 1'b0 && done === 1'b0, "R1", "busy/done in reset", int'(busy), 0);
    check(mem_we === 1'b0 && tbl_re === 1'b0, "R1", "no access in reset", int'(mem_we), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(busy === 1'b0 && done === 1'b0 && mem_we === 1'b0, "R1", "idle after reset", int'(busy), 0);
  endtask

  task automatic t_random(input string name, input bit poke);
    int st = 12345;
    int cyc;
    for (int p = 0; p < N; p++) begin
      st = st * 1103515245 + 12345;
      in_re[p] = 16'(((st >>> 8) & 16'h3fff) - 8192);
      st = st * 1103515245 + 12345;
      in_im[p] = 16'(((st >>> 8) & 16'h3fff) - 8192);
    end
    run_fft(name, poke, cyc);
    if (!poke) ref_cycles = cyc;
    else check(cyc == ref_cycles, "R3", "restart ignored: run length", cyc, ref_cycles);
  endtask

  task automatic t_dc();
    int cyc;
    bit ok = 1;
    for (int p = 0; p < N; p++) begin in_re[p] = 16'sd8000; in_im[p] = 16'sd0; end
    run_fft("dc", 1'b0, cyc);
    check((int'(m_re[0]) - 8000) <= TOL && (8000 - int'(m_re[0])) <= TOL,
          "R8", "dc bin 0", int'(m_re[0]), 8000);
    for (int p = 1; p < N; p++)
      if (int'(m_re[p]) > TOL || int'(m_re[p]) < -TOL ||
          int'(m_im[p]) > TOL || int'(m_im[p]) < -TOL) ok = 0;
    check(ok, "R8", "dc other bins near zero", int'(ok), 1);
  endtask

  task automatic t_impulse();
    int cyc;
    bit ok = 1;
    int lvl = 16000 / N;
    for (int p = 0; p < N; p++) begin in_re[p] = 16'sd0; in_im[p] = 16'sd0; end
    in_re[0] = 16'sd16000;
    run_fft("impulse", 1'b0, cyc);
    for (int p = 0; p < N; p++)
      if (int'(m_re[p]) - lvl > TOL || lvl - int'(m_re[p]) > TOL ||
          int'(m_im[p]) > TOL || int'(m_im[p]) < -TOL) ok = 0;
    check(ok, "R8", "impulse flat spectrum", int'(m_re[N/2]), lvl);
  endtask

  initial begin
    for (int i = 0; i < N; i++)
      sin_tab[i] = 16'(int'(32767.0 * $sin(2.0 * 3.14159265358979 * i / N)));
  end

  initial begin
    #400000;
    errors++;
    $display("FAIL R2 watchdog: actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_random("random", 1'b0);
    t_dc();
    t_impulse();
    t_random("restart", 1'b1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule